// File: doc/BRIEF.md
# Prefixed Vector Instruction Decoder

This block decodes a 48-bit instruction word that consists of a 16-bit vector prefix wrapped around a 32-bit base instruction. The upper 30 bits of the word are the base instruction without its two lowest bits. The prefix bits 17:6 hold extended register bits, per-operand scalar/vector flags, a packed type/predicate field and, for memory forms, a load/store kind. A format class, derived from the base opcode by the fetch stage, tells the decoder which prefix layout applies.

Each decode produces the rebuilt 32-bit base instruction, 7-bit physical register numbers for rd, rs1, rs2 and rs3, a vector flag per operand, the sub-vector length, the element type, the source and destination predicate selectors and the load/store kind. One flag covers every form that has no legal meaning. All outputs are registered, so the result of the word presented in one cycle appears after the next rising clock edge.

Class codes: 0 load, 1 store, 2 integer R, 3 integer I, 4 integer U, 5 float R, 6 float I, 7 float R4. Codes 8 to 15 are base instructions with no prefixed form (system, branch, jump, integer store and others).

Top module: `pvd_decoder`

## Requirements
- R1: A word whose bits 5:0 differ from 011111 raises `illegal_o`.
- R2: `base_o` equals {insn[47:18], 2'b11}, one clock after the word is presented.
- R3: An operand in scalar mode gets the 6-bit field {prefix bit, base 5-bit field} zero-extended to 7 bits. The prefix bits are rd 17, rs1 16, rs2 15, rs3 13, and the base fields are rd 11:7, rs1 19:15, rs2 24:20, rs3 31:27. Operands the class does not use read 0 and are scalar.
- R4: An operand in vector mode gets the number {f[0], f[5:1], 0} from its 6-bit field f.
- R5: Vector flags sit at bit 14 (rs2 for classes 2 and 5; rd for 3, 4 and 6), bit 13 (rs1 for 2, 3, 5 and 6) and bit 12 (rs3 for 7), with rs2 of class 7 at bit 14. A used operand with no flag of its own takes the OR of the flags its class carries. Classes 0 and 1 are all scalar.
- R6: `svlen_o` decodes the 2-bit length code as 00→4, 01→1, 10→2, 11→3. Classes 8 to 15 read 4.
- R7: Classes 5 and 7 take a 5-bit field from bits 11:7. It is reserved (illegal) when its bits 4:2 equal 001. Otherwise the predicate code is bits 4:2, the length code is bits 1:0 and `itype_o` is 0.
- R8: Classes 2 and 4 take a 6-bit field from bits 12:7. It is reserved when its bits 3:2 equal 01. Otherwise `itype_o` is bits 5:4, the predicate code is {0, bits 3:2} and the length code is bits 1:0.
- R9: Classes 0, 1, 3 and 6 take a 7-bit twin field t, with t[5:0] from bits 12:7 and t[6] from bit 6 (classes 0 and 1) or bit 15 (classes 3 and 6). `itype_o` is t[5:4] and the length code is t[1:0]. The source predicate is enabled by t[2] and the destination predicate by t[3], and t[6]=1 inverts both. `twin_o` is 1.
- R10: A single predicate code of 000 gives no predicate. A code of 001 gives no predicate and is illegal. The other codes select register 8+code[2:1] (9, 10 or 11), with `pred_on1_o`=code[0]. With twin predicates the source register is 9 and the destination register is 10. `pred_on1_o` and `dst_on1_o` are 1 for an enabled selector that is not inverted. Disabled selectors read 0.
- R11: `lsk_o` is insn[15:13] for class 0 and {insn[17], insn[14:13]} for class 1. It is 0 otherwise.
- R12: `illegal_o` is raised for classes 8 to 15, for a reserved type pattern, and for a non-zero reserved prefix bit: bit 6 in classes 2, 3, 6 and 7, bits 16, 15, 13 and 6 in class 4, and bits 12 and 6 in class 5.
- R13: While reset is held, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 48 | Prefixed instruction word |
| class_i | input | 4 | Format class from the base opcode |
| base_o | output | 32 | Rebuilt base instruction |
| rd_o | output | 7 | Destination register number |
| rs1_o | output | 7 | First source register number |
| rs2_o | output | 7 | Second source register number |
| rs3_o | output | 7 | Third source register number |
| vec_o | output | 4 | Vector flags: bit0 rd, bit1 rs1, bit2 rs2, bit3 rs3 |
| svlen_o | output | 3 | Sub-vector length, 1 to 4 |
| itype_o | output | 2 | Element type code |
| twin_o | output | 1 | Twin predicate form in use |
| pred_en_o | output | 1 | Single or source predicate enabled |
| pred_reg_o | output | 5 | Single or source predicate register |
| pred_on1_o | output | 1 | Execute where the predicate bit is 1 |
| dst_en_o | output | 1 | Destination predicate enabled |
| dst_reg_o | output | 5 | Destination predicate register |
| dst_on1_o | output | 1 | Destination executes where the bit is 1 |
| lsk_o | output | 3 | Load/store kind |
| illegal_o | output | 1 | Reserved or illegal encoding |

## Verification
On every cycle the assertions check the base pass-through and its one-cycle latency, the illegal flag for a missing prefix mark or an unsupported class, and the length range. They also check that scalar numbers never use bit 6, that vector numbers are always even, and that enabled predicates name only registers 9 to 11. Only the bench's sweep shows that the right prefix bit feeds each operand, that the OR rule picks up the flags, and that the exact reserved patterns of each packed field raise the flag. The bench covers every value of prefix bits 17:6 for every class.

// File: rtl/pvd_pkg.sv
package pvd_pkg;
  localparam int INSN_W      = 48;
  localparam int BASE_W      = 32;
  localparam int CLASS_W     = 4;
  localparam int FIELD_W     = 6;
  localparam int REGNUM_W    = 7;
  localparam int NUM_OPS     = 4;
  localparam int SVL_W       = 3;
  localparam int ITYPE_W     = 2;
  localparam int PCODE_W     = 3;
  localparam int PREG_W      = 5;
  localparam int LSK_W       = 3;
  localparam int TBITS_W     = 7;
  localparam int PFX_LO      = 6;
  localparam int PFX_HI      = 17;
  localparam int PFX_W       = PFX_HI - PFX_LO + 1;
  localparam int MARK_W      = 6;
  localparam logic [MARK_W-1:0] PFX_MARK = 6'b011111;
  localparam int NUM_CLASSES = 8;

  localparam int OP_RD  = 0;
  localparam int OP_RS1 = 1;
  localparam int OP_RS2 = 2;
  localparam int OP_RS3 = 3;

  localparam logic [PREG_W-1:0] PREG_BASE = 5'd8;
  localparam logic [PREG_W-1:0] PREG_SRC  = 5'd9;
  localparam logic [PREG_W-1:0] PREG_DST  = 5'd10;

  typedef enum logic [CLASS_W-1:0] {
    CL_LOAD  = 4'd0,
    CL_STORE = 4'd1,
    CL_INT_R = 4'd2,
    CL_INT_I = 4'd3,
    CL_INT_U = 4'd4,
    CL_FP_R  = 4'd5,
    CL_FP_I  = 4'd6,
    CL_FP_R4 = 4'd7
  } class_e;

  typedef enum logic [1:0] {
    TF_NONE = 2'd0,
    TF_TWIN = 2'd1,
    TF_INT6 = 2'd2,
    TF_FP5  = 2'd3
  } tfield_e;

  // Static shape of one class: operands used, flag slots, reserved bits.
  typedef struct packed {
    logic                 known;
    logic [NUM_OPS-1:0]   used;
    logic [NUM_OPS-1:0]   has_flag;
    logic [PFX_W-1:0]     rsv_mask;
    tfield_e              tf;
  } shape_t;

  function automatic shape_t shape_of(input logic [CLASS_W-1:0] cls);
    shape_t s;
    s = '0;
    s.tf = TF_NONE;
    case (cls)
      CL_LOAD:  begin s.known = 1'b1; s.used = 4'b0011; s.tf = TF_TWIN; end
      CL_STORE: begin s.known = 1'b1; s.used = 4'b0110; s.tf = TF_TWIN; end
      CL_INT_R: begin
        s.known = 1'b1; s.used = 4'b0111; s.has_flag = 4'b0110;
        s.rsv_mask = 12'h001; s.tf = TF_INT6;
      end
      CL_INT_I, CL_FP_I: begin
        s.known = 1'b1; s.used = 4'b0011; s.has_flag = 4'b0011;
        s.rsv_mask = 12'h001; s.tf = TF_TWIN;
      end
      CL_INT_U: begin
        s.known = 1'b1; s.used = 4'b0001; s.has_flag = 4'b0001;
        s.rsv_mask = 12'h681; s.tf = TF_INT6;
      end
      CL_FP_R: begin
        s.known = 1'b1; s.used = 4'b0111; s.has_flag = 4'b0110;
        s.rsv_mask = 12'h041; s.tf = TF_FP5;
      end
      CL_FP_R4: begin
        s.known = 1'b1; s.used = 4'b1111; s.has_flag = 4'b1100;
        s.rsv_mask = 12'h001; s.tf = TF_FP5;
      end
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pvd_layout.sv
module pvd_layout
  import pvd_pkg::*;
(
  input  logic [INSN_W-1:0]                insn,
  input  logic [CLASS_W-1:0]               cls,
  output logic [NUM_OPS-1:0][FIELD_W-1:0]  fields,
  output logic [NUM_OPS-1:0]               used,
  output logic [NUM_OPS-1:0]               vec,
  output tfield_e                          tf_kind,
  output logic [TBITS_W-1:0]               tbits,
  output logic [LSK_W-1:0]                 lsk,
  output logic                             known,
  output logic                             rsv_hit
);
  // Offset between base instruction bit positions and word bit positions.
  localparam int SH = INSN_W - BASE_W;

  shape_t              shp;
  logic [NUM_OPS-1:0]  raw_flag;
  logic                flag_or;
  logic [PFX_W-1:0]    pfx;

  assign shp     = shape_of(cls);
  assign pfx     = insn[PFX_HI:PFX_LO];
  assign known   = shp.known;
  assign used    = shp.used;
  assign tf_kind = shp.tf;
  assign rsv_hit = |(pfx & shp.rsv_mask);

  assign fields[OP_RD]  = {insn[17], insn[11+SH:7+SH]};
  assign fields[OP_RS1] = {insn[16], insn[19+SH:15+SH]};
  assign fields[OP_RS2] = {insn[15], insn[24+SH:20+SH]};
  assign fields[OP_RS3] = {insn[13], insn[31+SH:27+SH]};

  always_comb begin
    raw_flag = '0;
    case (cls)
      CL_INT_R, CL_FP_R: begin
        raw_flag[OP_RS2] = insn[14];
        raw_flag[OP_RS1] = insn[13];
      end
      CL_INT_I, CL_FP_I: begin
        raw_flag[OP_RD]  = insn[14];
        raw_flag[OP_RS1] = insn[13];
      end
      CL_INT_U: raw_flag[OP_RD] = insn[14];
      CL_FP_R4: begin
        raw_flag[OP_RS2] = insn[14];
        raw_flag[OP_RS3] = insn[12];
      end
      default: raw_flag = '0;
    endcase
  end

  assign flag_or = |(raw_flag & shp.has_flag);

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_flag
    assign vec[g] = shp.used[g] & (shp.has_flag[g] ? raw_flag[g] : flag_or);
  end

  always_comb begin
    tbits = '0;
    case (cls)
      CL_LOAD, CL_STORE: tbits = {insn[6],  insn[12:7]};
      CL_INT_I, CL_FP_I: tbits = {insn[15], insn[12:7]};
      CL_INT_R, CL_INT_U: tbits = {1'b0,    insn[12:7]};
      CL_FP_R, CL_FP_R4:  tbits = {2'b00,   insn[11:7]};
      default:            tbits = '0;
    endcase
  end

  always_comb begin
    case (cls)
      CL_LOAD:  lsk = insn[15:13];
      CL_STORE: lsk = {insn[17], insn[14:13]};
      default:  lsk = '0;
    endcase
  end
endmodule

// File: rtl/pvd_operand.sv
module pvd_operand
  import pvd_pkg::*;
(
  input  logic [FIELD_W-1:0]  field,
  input  logic                used,
  input  logic                vec,
  output logic [REGNUM_W-1:0] num
);
  logic [REGNUM_W-1:0] scalar_num;
  logic [REGNUM_W-1:0] vector_num;

  assign scalar_num = {{(REGNUM_W-FIELD_W){1'b0}}, field};
  assign vector_num = {field[0], field[FIELD_W-1:1], 1'b0};
  assign num = !used ? '0 : (vec ? vector_num : scalar_num);
endmodule

// File: rtl/pvd_typefield.sv
module pvd_typefield
  import pvd_pkg::*;
(
  input  tfield_e              kind,
  input  logic [TBITS_W-1:0]   tbits,
  output logic [SVL_W-1:0]     svlen,
  output logic [ITYPE_W-1:0]   itype,
  output logic                 twin,
  output logic                 pred_en,
  output logic [PREG_W-1:0]    pred_reg,
  output logic                 pred_on1,
  output logic                 dst_en,
  output logic [PREG_W-1:0]    dst_reg,
  output logic                 dst_on1,
  output logic                 rsv
);
  logic [PCODE_W-1:0] code;
  logic               single;

  assign svlen = (tbits[1:0] == 2'b00) ? SVL_W'(4) : {1'b0, tbits[1:0]};

  always_comb begin
    itype    = '0;
    twin     = 1'b0;
    single   = 1'b0;
    code     = '0;
    pred_en  = 1'b0;
    pred_reg = '0;
    pred_on1 = 1'b0;
    dst_en   = 1'b0;
    dst_reg  = '0;
    dst_on1  = 1'b0;
    rsv      = 1'b0;
    case (kind)
      TF_TWIN: begin
        itype    = tbits[5:4];
        twin     = 1'b1;
        pred_en  = tbits[2];
        pred_reg = tbits[2] ? PREG_SRC : '0;
        pred_on1 = tbits[2] & ~tbits[6];
        dst_en   = tbits[3];
        dst_reg  = tbits[3] ? PREG_DST : '0;
        dst_on1  = tbits[3] & ~tbits[6];
      end
      TF_INT6: begin
        itype  = tbits[5:4];
        single = 1'b1;
        code   = {1'b0, tbits[3:2]};
      end
      TF_FP5: begin
        single = 1'b1;
        code   = tbits[4:2];
      end
      default: ;
    endcase
    if (single) begin
      if (code == 3'b001) begin
        rsv = 1'b1;
      end else if (code != 3'b000) begin
        pred_en  = 1'b1;
        pred_reg = PREG_BASE + PREG_W'(code[2:1]);
        pred_on1 = code[0];
      end
    end
  end
endmodule

// File: rtl/pvd_decoder.sv
module pvd_decoder
  import pvd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [47:0]          insn_i,
  input  logic [3:0]           class_i,
  output logic [31:0]          base_o,
  output logic [6:0]           rd_o,
  output logic [6:0]           rs1_o,
  output logic [6:0]           rs2_o,
  output logic [6:0]           rs3_o,
  output logic [3:0]           vec_o,
  output logic [2:0]           svlen_o,
  output logic [1:0]           itype_o,
  output logic                 twin_o,
  output logic                 pred_en_o,
  output logic [4:0]           pred_reg_o,
  output logic                 pred_on1_o,
  output logic                 dst_en_o,
  output logic [4:0]           dst_reg_o,
  output logic                 dst_on1_o,
  output logic [2:0]           lsk_o,
  output logic                 illegal_o
);
  logic [NUM_OPS-1:0][FIELD_W-1:0]  fields;
  logic [NUM_OPS-1:0]               used;
  logic [NUM_OPS-1:0]               vec;
  logic [NUM_OPS-1:0][REGNUM_W-1:0] nums;
  tfield_e                          tf_kind;
  logic [TBITS_W-1:0]               tbits;
  logic [LSK_W-1:0]                 lsk;
  logic                             known;
  logic                             rsv_hit;

  logic [SVL_W-1:0]   svlen_c;
  logic [ITYPE_W-1:0] itype_c;
  logic               twin_c, pen_c, pon_c, den_c, don_c, tf_rsv;
  logic [PREG_W-1:0]  preg_c, dreg_c;
  logic               illegal_c;
  logic [BASE_W-1:0]  base_c;

  pvd_layout u_layout (
    .insn    (insn_i),
    .cls     (class_i),
    .fields  (fields),
    .used    (used),
    .vec     (vec),
    .tf_kind (tf_kind),
    .tbits   (tbits),
    .lsk     (lsk),
    .known   (known),
    .rsv_hit (rsv_hit)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    pvd_operand u_op (
      .field (fields[g]),
      .used  (used[g]),
      .vec   (vec[g]),
      .num   (nums[g])
    );
  end

  pvd_typefield u_tf (
    .kind     (tf_kind),
    .tbits    (tbits),
    .svlen    (svlen_c),
    .itype    (itype_c),
    .twin     (twin_c),
    .pred_en  (pen_c),
    .pred_reg (preg_c),
    .pred_on1 (pon_c),
    .dst_en   (den_c),
    .dst_reg  (dreg_c),
    .dst_on1  (don_c),
    .rsv      (tf_rsv)
  );

  assign base_c    = {insn_i[INSN_W-1:INSN_W-BASE_W+2], 2'b11};
  assign illegal_c = (insn_i[MARK_W-1:0] != PFX_MARK) | ~known | rsv_hit | tf_rsv;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o     <= '0;
      rd_o       <= '0;
      rs1_o      <= '0;
      rs2_o      <= '0;
      rs3_o      <= '0;
      vec_o      <= '0;
      svlen_o    <= '0;
      itype_o    <= '0;
      twin_o     <= 1'b0;
      pred_en_o  <= 1'b0;
      pred_reg_o <= '0;
      pred_on1_o <= 1'b0;
      dst_en_o   <= 1'b0;
      dst_reg_o  <= '0;
      dst_on1_o  <= 1'b0;
      lsk_o      <= '0;
      illegal_o  <= 1'b0;
    end else begin
      base_o     <= base_c;
      rd_o       <= nums[OP_RD];
      rs1_o      <= nums[OP_RS1];
      rs2_o      <= nums[OP_RS2];
      rs3_o      <= nums[OP_RS3];
      vec_o      <= vec;
      svlen_o    <= svlen_c;
      itype_o    <= itype_c;
      twin_o     <= twin_c;
      pred_en_o  <= pen_c;
      pred_reg_o <= preg_c;
      pred_on1_o <= pon_c;
      dst_en_o   <= den_c;
      dst_reg_o  <= dreg_c;
      dst_on1_o  <= don_c;
      lsk_o      <= lsk;
      illegal_o  <= illegal_c;
    end
  end
endmodule

// File: rtl/pvd_decoder_chk.sv
module pvd_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [47:0] insn_i,
  input logic [3:0]  class_i,
  input logic [31:0] base_o,
  input logic [6:0]  rd_o,
  input logic [6:0]  rs1_o,
  input logic [6:0]  rs2_o,
  input logic [6:0]  rs3_o,
  input logic [3:0]  vec_o,
  input logic [2:0]  svlen_o,
  input logic [1:0]  itype_o,
  input logic        twin_o,
  input logic        pred_en_o,
  input logic [4:0]  pred_reg_o,
  input logic        pred_on1_o,
  input logic        dst_en_o,
  input logic [4:0]  dst_reg_o,
  input logic        dst_on1_o,
  input logic [2:0]  lsk_o,
  input logic        illegal_o
);
  logic [3:0][6:0] nums;
  assign nums = {rs3_o, rs2_o, rs1_o, rd_o};

  p_not_prefixed_r1: assert property (@(posedge clk) disable iff (rst)
    (insn_i[5:0] != 6'b011111) |=> illegal_o);

  p_base_passthru_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (base_o == {$past(insn_i[47:18]), 2'b11}));

  for (genvar g = 0; g < 4; g++) begin : g_ops
    p_scalar_narrow_r3: assert property (@(posedge clk) disable iff (rst)
      !vec_o[g] |-> (nums[g][6] == 1'b0));
    p_vector_even_r4: assert property (@(posedge clk) disable iff (rst)
      vec_o[g] |-> (nums[g][0] == 1'b0));
  end

  p_svlen_range_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (svlen_o >= 3'd1 && svlen_o <= 3'd4));

  p_pred_reg_r10: assert property (@(posedge clk) disable iff (rst)
    pred_en_o |-> (pred_reg_o >= 5'd9 && pred_reg_o <= 5'd11));

  p_dst_twin_r9: assert property (@(posedge clk) disable iff (rst)
    dst_en_o |-> (twin_o && dst_reg_o == 5'd10));

  p_unsupported_r12: assert property (@(posedge clk) disable iff (rst)
    (class_i >= 4'd8) |=> illegal_o);
endmodule

bind pvd_decoder pvd_decoder_chk i_chk (.*);

// File: tb/test_pvd_decoder.sv
module test_pvd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] insn_i = '0;
  logic [3:0]  class_i = '0;
  logic [31:0] base_o;
  logic [6:0]  rd_o, rs1_o, rs2_o, rs3_o;
  logic [3:0]  vec_o;
  logic [2:0]  svlen_o;
  logic [1:0]  itype_o;
  logic        twin_o, pred_en_o, pred_on1_o, dst_en_o, dst_on1_o, illegal_o;
  logic [4:0]  pred_reg_o, dst_reg_o;
  logic [2:0]  lsk_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  pvd_decoder i_pvd_decoder (.*);

  always #4 clk = ~clk;

  // expected values
  logic [31:0] e_base;
  logic [6:0]  e_num [4];
  logic [3:0]  e_vec;
  logic [2:0]  e_sv;
  logic [1:0]  e_it;
  logic        e_twin, e_pen, e_pon, e_den, e_don, e_ill;
  logic [4:0]  e_preg, e_dreg;
  logic [2:0]  e_lsk;
  string       e_ttag;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (insn %h class %0d)", tag, what, act, exp, insn_i, class_i);
    end
  endtask

  task automatic model(input logic [47:0] w, input int c);
    logic [5:0] f [4];
    logic [3:0] u;
    logic d, s1, s2, s3, bad, rsvb;
    logic [6:0] t;
    logic [2:0] p;
    logic [1:0] code;
    e_base = {w[47:18], 2'b11};
    f[0] = {w[17], w[27:23]};
    f[1] = {w[16], w[35:31]};
    f[2] = {w[15], w[40:36]};
    f[3] = {w[13], w[47:43]};
    u = 4'b0000; d = 0; s1 = 0; s2 = 0; s3 = 0;
    if (c == 0)                u = 4'b0011;
    else if (c == 1)           u = 4'b0110;
    else if (c == 2 || c == 5) begin u = 4'b0111; s2 = w[14]; s1 = w[13]; d = s1 | s2; end
    else if (c == 3 || c == 6) begin u = 4'b0011; d = w[14]; s1 = w[13]; end
    else if (c == 4)           begin u = 4'b0001; d = w[14]; end
    else if (c == 7)           begin u = 4'b1111; s2 = w[14]; s3 = w[12]; d = s2 | s3; s1 = d; end
    e_vec = u & {s3, s2, s1, d};
    for (int k = 0; k < 4; k++) begin
      if (!u[k])         e_num[k] = 7'd0;
      else if (e_vec[k]) e_num[k] = {f[k][0], f[k][5:1], 1'b0};
      else               e_num[k] = {1'b0, f[k]};
    end
    e_it = 0; e_twin = 0; e_pen = 0; e_pon = 0; e_den = 0; e_don = 0;
    e_preg = 0; e_dreg = 0; bad = 0; code = 2'b00; p = 0; e_ttag = "R6";
    if (c == 0 || c == 1 || c == 3 || c == 6) begin
      t = (c <= 1) ? {w[6], w[12:7]} : {w[15], w[12:7]};
      e_ttag = "R9";
      e_twin = 1; e_it = t[5:4]; code = t[1:0];
      e_pen = t[2]; e_preg = t[2] ? 5'd9 : 5'd0; e_pon = t[2] && !t[6];
      e_den = t[3]; e_dreg = t[3] ? 5'd10 : 5'd0; e_don = t[3] && !t[6];
    end else if (c == 2 || c == 4 || c == 5 || c == 7) begin
      if (c == 2 || c == 4) begin
        e_ttag = "R8"; e_it = w[12:11]; p = {1'b0, w[10:9]}; code = w[8:7];
      end else begin
        e_ttag = "R7"; p = w[11:9]; code = w[8:7];
      end
      if (p == 3'd1) bad = 1;
      else if (p != 3'd0) begin
        e_pen = 1; e_pon = p[0];
        e_preg = (p[2:1] == 2'b01) ? 5'd9 : (p[2:1] == 2'b10) ? 5'd10 : 5'd11;
      end
    end
    e_sv = (code == 2'b00) ? 3'd4 : {1'b0, code};
    e_lsk = (c == 0) ? w[15:13] : (c == 1) ? {w[17], w[14], w[13]} : 3'd0;
    rsvb = 0;
    if (c == 2 || c == 3 || c == 6 || c == 7) rsvb = w[6];
    else if (c == 4) rsvb = w[16] | w[15] | w[13] | w[6];
    else if (c == 5) rsvb = w[12] | w[6];
    e_ill = (w[5:0] != 6'b011111) || (c >= 8) || rsvb || bad;
  endtask

  task automatic apply(input logic [47:0] w, input int c, input string itag);
    @(negedge clk);
    insn_i = w; class_i = 4'(c);
    model(w, c);
    @(negedge clk);
    chk("R2", "base", base_o, e_base);
    chk(e_vec[0] ? "R4" : "R3", "rd",  rd_o,  e_num[0]);
    chk(e_vec[1] ? "R4" : "R3", "rs1", rs1_o, e_num[1]);
    chk(e_vec[2] ? "R4" : "R3", "rs2", rs2_o, e_num[2]);
    chk(e_vec[3] ? "R4" : "R3", "rs3", rs3_o, e_num[3]);
    chk("R5", "vec", vec_o, e_vec);
    chk("R6", "svlen", svlen_o, e_sv);
    chk(e_ttag, "itype", itype_o, e_it);
    chk(e_ttag, "twin", twin_o, e_twin);
    chk("R10", "pred", {pred_en_o, pred_reg_o, pred_on1_o}, {e_pen, e_preg, e_pon});
    chk("R10", "dst", {dst_en_o, dst_reg_o, dst_on1_o}, {e_den, e_dreg, e_don});
    chk("R11", "lsk", lsk_o, e_lsk);
    chk(itag, "illegal", illegal_o, e_ill);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    insn_i  = 48'hFFFF_FFFF_FFDF;
    class_i = 4'd7;
    repeat (3) @(negedge clk);
    // R13: outputs held at zero under reset
    chk("R13", "base", base_o, 0);
    chk("R13", "regs", {rd_o, rs1_o, rs2_o, rs3_o}, 0);
    chk("R13", "flags", {vec_o, svlen_o, itype_o, twin_o, pred_en_o, dst_en_o, lsk_o, illegal_o}, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int c = 0; c < 9; c++) begin
      for (int p = 0; p < 4096; p++) begin
        logic [29:0] hi;
        hi = 30'(p * 32'h0009_E377 + c * 32'h1555_5555 + 32'h2B3C_0D1E);
        apply({hi, 12'(p), 6'b011111}, c, "R12");
      end
    end
    apply({30'h1234_5678, 12'h000, 6'b011111}, 12, "R12");
    apply({30'h3FFF_FFFF, 12'hFFF, 6'b011111}, 15, "R12");
    // R1: missing prefix mark
    apply({30'h0ABC_DEF0, 12'h000, 6'b011110}, 2, "R1");
    apply({30'h0ABC_DEF0, 12'h000, 6'b111111}, 0, "R1");
    apply({30'h0000_0001, 12'h3C4, 6'b000011}, 5, "R1");
    apply({30'h2222_2222, 12'h0F0, 6'b011111}, 3, "R1");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule